// File: doc/BRIEF.md
# Condition Register Logic Unit

This is a purely combinational execution stage for a 32-bit condition register made of eight 4-bit fields. Each cycle it receives an operation code, the raw instruction word, the current condition register value and a general-purpose operand. It returns the updated condition register and a flag that says whether the register was written. A pipeline places it between operand read and write-back.

It supports three operations:

- **Bit logic.** Two single condition bits are combined through a 4-entry truth table that the instruction itself carries. The result is written into one target bit.
- **Field copy.** One whole 4-bit field is copied onto another.
- **Masked move.** Selected fields of the general-purpose operand are written into the register under an 8-bit field-select value.

Field copy and masked move are built from whole-register shifts and masks. There is no per-bit index decoder. Bit positions use big-endian numbering: condition bit 0 is the register's most significant bit, and field 0 occupies bits 31:28.

Top module: `cr_logic_unit`

## Requirements
- R1: An operation code other than 1 (bit logic), 2 (field copy) or 3 (masked move) returns `cr_out` equal to `cr_in` with `cr_ok` low.
- R2: For bit logic (code 1), the truth table is `insn[9:6]`, with entry i equal to `insn[6+i]`. The entry is selected by index {A,B}, with A as the high index bit: A=0,B=0 selects entry 0, A=0,B=1 entry 1, A=1,B=0 entry 2, and A=1,B=1 entry 3.
- R3: For bit logic, A is condition bit `insn[20:16]` and B is condition bit `insn[15:11]`. The result goes to condition bit `insn[25:21]`. Condition bit n is register bit 31-n. A and B may name the same bit.
- R4: Bit logic leaves the other 31 bits equal to `cr_in` and raises `cr_ok`.
- R5: Field copy writes source field `insn[20:18]` into destination field `insn[25:23]`, where field f is register bits 31-4f down to 28-4f. All other fields are unchanged, `cr_ok` is high, and equal source and destination return `cr_in`.
- R6: Masked move takes field-select `insn[19:12]`. Bit j of the field-select covers register bits 4j+3..4j. The output is `(gpr_in & mask) | (cr_in & ~mask)`.
- R7: Masked move raises `cr_ok` only when the field-select is non-zero. An all-zero field-select leaves `cr_out` equal to `cr_in`, and an all-ones field-select returns `gpr_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_kind | input | 3 | Operation code: 1 bit logic, 2 field copy, 3 masked move |
| insn | input | 32 | Raw instruction word holding fields and truth table |
| cr_in | input | 32 | Current condition register value |
| gpr_in | input | 32 | General-purpose source operand for the masked move |
| cr_out | output | 32 | Updated condition register value |
| cr_ok | output | 1 | High when the operation wrote the condition register |

## Verification
The bench builds the block with its default parameters: eight 4-bit fields, a 32-bit instruction word, and field positions at their standard offsets. With these values a literal field index maps straight to a register bit, so hand-worked vectors can hit the extreme positions directly. These include condition bits 0 and 31, fields 0 and 7, and field-select values 0x00, 0xFF and 0x81. Randomised operands and instruction words then exercise every truth-table entry and every shift distance. Forced cases cover A and B naming the same bit and a field copied onto itself.

// File: rtl/cr_unit_pkg.sv
package cr_unit_pkg;

   typedef enum logic [2:0] {
      CRU_NOP   = 3'd0,
      CRU_LOGIC = 3'd1,
      CRU_FCOPY = 3'd2,
      CRU_MOVE  = 3'd3
   } cru_op_e;

   localparam int unsigned CRU_LUT_W = 4;

endpackage

// File: rtl/cr_bit_logic.sv
module cr_bit_logic #(
   parameter int unsigned CR_W  = 32,
   parameter int unsigned IDX_W = 5,
   parameter int unsigned LUT_W = 4
) (
   input  logic [CR_W-1:0]  cr_in,
   input  logic [IDX_W-1:0] src_a_idx,
   input  logic [IDX_W-1:0] src_b_idx,
   input  logic [IDX_W-1:0] dst_idx,
   input  logic [LUT_W-1:0] truth,
   output logic [CR_W-1:0]  cr_res
);
   localparam logic [CR_W-1:0] MSB_ONE = {1'b1, {(CR_W-1){1'b0}}};

   logic [CR_W-1:0] a_aligned;
   logic [CR_W-1:0] b_aligned;
   logic [CR_W-1:0] dst_mask;
   logic [1:0]      sel;
   logic            bit_val;

   always_comb begin
      // bring the addressed source bits to the top position by shifting
      a_aligned = cr_in << src_a_idx;
      b_aligned = cr_in << src_b_idx;
      sel       = {a_aligned[CR_W-1], b_aligned[CR_W-1]};
      bit_val   = truth[sel];
      dst_mask  = MSB_ONE >> dst_idx;
      cr_res    = (cr_in & ~dst_mask) | ({CR_W{bit_val}} & dst_mask);
   end

endmodule

// File: rtl/cr_field_copy.sv
module cr_field_copy #(
   parameter int unsigned FIELD_W  = 4,
   parameter int unsigned N_FIELDS = 8,
   parameter int unsigned FIDX_W   = 3
) (
   input  logic [FIELD_W*N_FIELDS-1:0] cr_in,
   input  logic [FIDX_W-1:0]           src_fld,
   input  logic [FIDX_W-1:0]           dst_fld,
   output logic [FIELD_W*N_FIELDS-1:0] cr_res
);
   localparam int unsigned CR_W = FIELD_W * N_FIELDS;
   localparam logic [CR_W-1:0] TOP_FIELD =
      {{FIELD_W{1'b1}}, {(CR_W-FIELD_W){1'b0}}};

   logic [CR_W-1:0]    src_aligned;
   logic [FIELD_W-1:0] src_bits;
   logic [CR_W-1:0]    placed;
   logic [CR_W-1:0]    dst_mask;
   int unsigned        src_shift;
   int unsigned        dst_shift;

   always_comb begin
      src_shift   = FIELD_W * 32'(src_fld);
      dst_shift   = FIELD_W * 32'(dst_fld);
      // one shift lifts the source field to the top, one drops it into place
      src_aligned = cr_in << src_shift;
      src_bits    = src_aligned[CR_W-1 -: FIELD_W];
      placed      = {src_bits, {(CR_W-FIELD_W){1'b0}}} >> dst_shift;
      dst_mask    = TOP_FIELD >> dst_shift;
      cr_res      = (cr_in & ~dst_mask) | placed;
   end

endmodule

// File: rtl/cr_masked_move.sv
module cr_masked_move #(
   parameter int unsigned FIELD_W  = 4,
   parameter int unsigned N_FIELDS = 8
) (
   input  logic [FIELD_W*N_FIELDS-1:0] cr_in,
   input  logic [FIELD_W*N_FIELDS-1:0] src_val,
   input  logic [N_FIELDS-1:0]         fld_sel,
   output logic [FIELD_W*N_FIELDS-1:0] cr_res,
   output logic                        any_sel
);
   localparam int unsigned CR_W = FIELD_W * N_FIELDS;

   logic [CR_W-1:0] mask;

   for (genvar g = 0; g < N_FIELDS; g++) begin : g_expand
      assign mask[g*FIELD_W +: FIELD_W] = {FIELD_W{fld_sel[g]}};
   end

   assign cr_res  = (src_val & mask) | (cr_in & ~mask);
   assign any_sel = |fld_sel;

endmodule

// File: rtl/cr_logic_unit.sv
module cr_logic_unit #(
   parameter int unsigned CR_FIELD_W = 4,
   parameter int unsigned CR_FIELDS  = 8,
   parameter int unsigned INSN_W     = 32,
   parameter int unsigned GPR_W      = 32,
   parameter int unsigned OP_W       = 3,
   parameter int unsigned LUT_LSB    = 6,
   parameter int unsigned BT_LSB     = 21,
   parameter int unsigned BA_LSB     = 16,
   parameter int unsigned BB_LSB     = 11,
   parameter int unsigned BF_LSB     = 23,
   parameter int unsigned BFA_LSB    = 18,
   parameter int unsigned FSEL_LSB   = 12
) (
   input  logic [OP_W-1:0]                  op_kind,
   input  logic [INSN_W-1:0]                insn,
   input  logic [CR_FIELD_W*CR_FIELDS-1:0]  cr_in,
   input  logic [GPR_W-1:0]                 gpr_in,
   output logic [CR_FIELD_W*CR_FIELDS-1:0]  cr_out,
   output logic                             cr_ok
);
   import cr_unit_pkg::*;

   localparam int unsigned CR_W   = CR_FIELD_W * CR_FIELDS;
   localparam int unsigned IDX_W  = $clog2(CR_W);
   localparam int unsigned FIDX_W = $clog2(CR_FIELDS);

   // elaboration-time parameter checks
   if ((CR_FIELDS & (CR_FIELDS - 1)) != 0 || CR_FIELDS < 2) begin : g_bad_fields
      $error("CR_FIELDS must be a power of two of at least 2");
   end
   if ((CR_FIELD_W & (CR_FIELD_W - 1)) != 0) begin : g_bad_fw
      $error("CR_FIELD_W must be a power of two");
   end
   if (GPR_W < CR_W) begin : g_bad_gpr
      $error("GPR_W must cover the condition register");
   end
   if (OP_W < 2) begin : g_bad_op
      $error("OP_W too narrow for the operation codes");
   end
   if (LUT_LSB + CRU_LUT_W > INSN_W || BT_LSB + IDX_W > INSN_W ||
       BA_LSB + IDX_W > INSN_W || BB_LSB + IDX_W > INSN_W ||
       BF_LSB + FIDX_W > INSN_W || BFA_LSB + FIDX_W > INSN_W ||
       FSEL_LSB + CR_FIELDS > INSN_W) begin : g_bad_pos
      $error("an instruction field lies outside the instruction word");
   end

   // field extraction
   logic [IDX_W-1:0]     f_bt, f_ba, f_bb;
   logic [FIDX_W-1:0]    f_bf, f_bfa;
   logic [CRU_LUT_W-1:0] f_lut;
   logic [CR_FIELDS-1:0] f_sel;

   assign f_bt  = insn[BT_LSB   +: IDX_W];
   assign f_ba  = insn[BA_LSB   +: IDX_W];
   assign f_bb  = insn[BB_LSB   +: IDX_W];
   assign f_bf  = insn[BF_LSB   +: FIDX_W];
   assign f_bfa = insn[BFA_LSB  +: FIDX_W];
   assign f_lut = insn[LUT_LSB  +: CRU_LUT_W];
   assign f_sel = insn[FSEL_LSB +: CR_FIELDS];

   logic unused_wide_inputs;
   assign unused_wide_inputs = ^{insn, gpr_in};

   logic [CR_W-1:0] logic_res, copy_res, move_res;
   logic            move_any;

   cr_bit_logic #(
      .CR_W  (CR_W),
      .IDX_W (IDX_W),
      .LUT_W (CRU_LUT_W)
   ) i_bit_logic (
      .cr_in     (cr_in),
      .src_a_idx (f_ba),
      .src_b_idx (f_bb),
      .dst_idx   (f_bt),
      .truth     (f_lut),
      .cr_res    (logic_res)
   );

   cr_field_copy #(
      .FIELD_W  (CR_FIELD_W),
      .N_FIELDS (CR_FIELDS),
      .FIDX_W   (FIDX_W)
   ) i_field_copy (
      .cr_in   (cr_in),
      .src_fld (f_bfa),
      .dst_fld (f_bf),
      .cr_res  (copy_res)
   );

   cr_masked_move #(
      .FIELD_W  (CR_FIELD_W),
      .N_FIELDS (CR_FIELDS)
   ) i_masked_move (
      .cr_in   (cr_in),
      .src_val (gpr_in[CR_W-1:0]),
      .fld_sel (f_sel),
      .cr_res  (move_res),
      .any_sel (move_any)
   );

   always_comb begin
      cr_out = cr_in;
      cr_ok  = 1'b0;
      case (op_kind)
         OP_W'(CRU_LOGIC): begin
            cr_out = logic_res;
            cr_ok  = 1'b1;
         end
         OP_W'(CRU_FCOPY): begin
            cr_out = copy_res;
            cr_ok  = 1'b1;
         end
         OP_W'(CRU_MOVE): begin
            cr_out = move_res;
            cr_ok  = move_any;
         end
         default: begin
            cr_out = cr_in;
            cr_ok  = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/cr_unit_chk.sv
module cr_unit_chk #(
   parameter int unsigned CR_FIELD_W = 4,
   parameter int unsigned CR_FIELDS  = 8,
   parameter int unsigned INSN_W     = 32,
   parameter int unsigned GPR_W      = 32,
   parameter int unsigned OP_W       = 3,
   parameter int unsigned LUT_LSB    = 6,
   parameter int unsigned BT_LSB     = 21,
   parameter int unsigned BA_LSB     = 16,
   parameter int unsigned BB_LSB     = 11,
   parameter int unsigned BF_LSB     = 23,
   parameter int unsigned BFA_LSB    = 18,
   parameter int unsigned FSEL_LSB   = 12
) (
   input logic [OP_W-1:0]                 op_kind,
   input logic [INSN_W-1:0]               insn,
   input logic [CR_FIELD_W*CR_FIELDS-1:0] cr_in,
   input logic [GPR_W-1:0]                gpr_in,
   input logic [CR_FIELD_W*CR_FIELDS-1:0] cr_out,
   input logic                            cr_ok
);
   localparam int unsigned CR_W   = CR_FIELD_W * CR_FIELDS;
   localparam int unsigned IDX_W  = $clog2(CR_W);
   localparam int unsigned FIDX_W = $clog2(CR_FIELDS);

   logic unused_chk_inputs;
   assign unused_chk_inputs = ^{insn, gpr_in};

   always_comb begin
      int unsigned     bt, ba, bb, bf, bfa;
      logic [3:0]      lut;
      logic [CR_W-1:0] fmask;
      logic            move_bad;
      logic [CR_FIELDS-1:0] fsel;

      bt   = 32'(insn[BT_LSB  +: IDX_W]);
      ba   = 32'(insn[BA_LSB  +: IDX_W]);
      bb   = 32'(insn[BB_LSB  +: IDX_W]);
      bf   = 32'(insn[BF_LSB  +: FIDX_W]);
      bfa  = 32'(insn[BFA_LSB +: FIDX_W]);
      lut  = insn[LUT_LSB +: 4];
      fsel = insn[FSEL_LSB +: CR_FIELDS];

      fmask = '0;
      for (int i = 0; i < int'(CR_FIELD_W); i++) begin
         fmask[CR_W-1 - bf*CR_FIELD_W - 32'(i)] = 1'b1;
      end

      move_bad = 1'b0;
      for (int k = 0; k < int'(CR_W); k++) begin
         if (fsel[k / int'(CR_FIELD_W)]) begin
            if (cr_out[k] != gpr_in[k]) move_bad = 1'b1;
         end else begin
            if (cr_out[k] != cr_in[k]) move_bad = 1'b1;
         end
      end

      if (op_kind == OP_W'(1)) begin
         // R2, R3: target bit follows the truth table entry
         a_r2_truth_entry: assert (cr_out[CR_W-1-bt] ==
                                   lut[{cr_in[CR_W-1-ba], cr_in[CR_W-1-bb]}])
            else $error("R2 truth table result mismatch");
         // R4: at most one bit differs and the write is flagged
         a_r4_single_bit: assert ($countones(cr_out ^ cr_in) <= 1 && cr_ok)
            else $error("R4 bit logic touched more than the target");
      end else if (op_kind == OP_W'(2)) begin
         a_r5_outside_field: assert ((((cr_out ^ cr_in) & ~fmask) == '0) && cr_ok)
            else $error("R5 field copy changed another field");
         if (bf == bfa) begin
            a_r5_self_copy: assert (cr_out == cr_in)
               else $error("R5 self copy altered the register");
         end
      end else if (op_kind == OP_W'(3)) begin
         a_r6_masked_merge: assert (!move_bad)
            else $error("R6 masked move merge mismatch");
         a_r7_move_ok: assert (cr_ok == (fsel != '0))
            else $error("R7 masked move ok flag mismatch");
      end else begin
         a_r1_nop_holds: assert (cr_out == cr_in && !cr_ok)
            else $error("R1 unsupported operation modified state");
      end
   end

endmodule

bind cr_logic_unit cr_unit_chk #(
   .CR_FIELD_W (CR_FIELD_W),
   .CR_FIELDS  (CR_FIELDS),
   .INSN_W     (INSN_W),
   .GPR_W      (GPR_W),
   .OP_W       (OP_W),
   .LUT_LSB    (LUT_LSB),
   .BT_LSB     (BT_LSB),
   .BA_LSB     (BA_LSB),
   .BB_LSB     (BB_LSB),
   .BF_LSB     (BF_LSB),
   .BFA_LSB    (BFA_LSB),
   .FSEL_LSB   (FSEL_LSB)
) i_cr_unit_chk (
   .op_kind (op_kind),
   .insn    (insn),
   .cr_in   (cr_in),
   .gpr_in  (gpr_in),
   .cr_out  (cr_out),
   .cr_ok   (cr_ok)
);

// File: tb/test_cr_logic_unit.sv
module test_cr_logic_unit;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYC = 200000;

   typedef struct packed {
      logic [2:0]  op;
      logic [31:0] insn;
      logic [31:0] cr;
      logic [31:0] gpr;
      logic [31:0] exp_cr;
      logic        exp_ok;
   } vec_t;

   // hand-worked vectors; comments give the requirement each one targets
   localparam int NVEC = 9;
   localparam vec_t VECS [NVEC] = '{
      // R2/R3: bt=0 ba=1 bb=2 lut=0110, A=1 B=0 -> entry 2 = 1
      '{3'd1, 32'h0001_1180, 32'h4000_0000, 32'h0, 32'hC000_0000, 1'b1},
      // R3/R4: bt=31 ba=bb=0 lut=1000, A=B=1 -> entry 3 = 1
      '{3'd1, 32'h03E0_0200, 32'h8000_0000, 32'h0, 32'h8000_0001, 1'b1},
      // R5: field 0 copied to field 7
      '{3'd2, 32'h0380_0000, 32'hA000_0005, 32'h0, 32'hA000_000A, 1'b1},
      // R5: field 2 onto itself
      '{3'd2, 32'h0108_0000, 32'h1234_5678, 32'h0, 32'h1234_5678, 1'b1},
      // R7: select all fields
      '{3'd3, 32'h000F_F000, 32'h1234_5678, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1},
      // R7: select nothing
      '{3'd3, 32'h0000_0000, 32'h1234_5678, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0},
      // R6: select 0x81 -> bits 31:28 and 3:0
      '{3'd3, 32'h0008_1000, 32'h1234_5678, 32'hDEAD_BEEF, 32'hD234_567F, 1'b1},
      // R1: code 0
      '{3'd0, 32'h0001_1180, 32'h55AA_55AA, 32'hFFFF_FFFF, 32'h55AA_55AA, 1'b0},
      // R1: code 7
      '{3'd7, 32'h000F_F000, 32'h55AA_55AA, 32'hFFFF_FFFF, 32'h55AA_55AA, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  op_kind = '0;
   logic [31:0] insn = '0;
   logic [31:0] cr_in = '0;
   logic [31:0] gpr_in = '0;
   logic [31:0] cr_out;
   logic        cr_ok;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cr_logic_unit i_cr_logic_unit (
      .op_kind (op_kind),
      .insn    (insn),
      .cr_in   (cr_in),
      .gpr_in  (gpr_in),
      .cr_out  (cr_out),
      .cr_ok   (cr_ok)
   );

   function automatic void ref_model(input logic [2:0] op, input logic [31:0] iw,
                                     input logic [31:0] cr, input logic [31:0] gpr,
                                     output logic [31:0] o, output logic ok);
      int bt, ba, bb, bf, bfa;
      logic a, b;
      logic [3:0] lut;
      logic [7:0] fsel;
      o  = cr;
      ok = 1'b0;
      case (op)
         3'd1: begin
            bt = int'(iw[25:21]); ba = int'(iw[20:16]); bb = int'(iw[15:11]);
            lut = iw[9:6];
            a = cr[31-ba]; b = cr[31-bb];
            o[31-bt] = lut[{a, b}];
            ok = 1'b1;
         end
         3'd2: begin
            bf = int'(iw[25:23]); bfa = int'(iw[20:18]);
            for (int i = 0; i < 4; i++) o[31-4*bf-i] = cr[31-4*bfa-i];
            ok = 1'b1;
         end
         3'd3: begin
            fsel = iw[19:12];
            for (int k = 0; k < 32; k++) if (fsel[k/4]) o[k] = gpr[k];
            ok = |fsel;
         end
         default: ;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] exp_cr, input logic exp_ok);
      checks++;
      if (cr_out !== exp_cr || cr_ok !== exp_ok) begin
         errors++;
         $display("FAIL %s: op=%0d insn=%h cr_in=%h gpr=%h actual cr=%h ok=%b expected cr=%h ok=%b",
                  tag, op_kind, insn, cr_in, gpr_in, cr_out, cr_ok, exp_cr, exp_ok);
      end
   endtask

   task automatic apply(input logic [2:0] op, input logic [31:0] iw,
                        input logic [31:0] cr, input logic [31:0] gpr);
      @(posedge clk);
      op_kind = op; insn = iw; cr_in = cr; gpr_in = gpr;
      @(negedge clk);
   endtask

   task automatic run_model(input string tag, input logic [2:0] op, input logic [31:0] iw,
                            input logic [31:0] cr, input logic [31:0] gpr);
      logic [31:0] e;
      logic eo;
      ref_model(op, iw, cr, gpr, e, eo);
      apply(op, iw, cr, gpr);
      check(tag, e, eo);
   endtask

   initial begin
      logic [31:0] iw;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: idle inputs during reset give an unwritten zero register
      check("R1 reset idle", 32'h0, 1'b0);
      rst = 1'b0;

      for (int v = 0; v < NVEC; v++) begin
         apply(VECS[v].op, VECS[v].insn, VECS[v].cr, VECS[v].gpr);
         check($sformatf("R1-R7 vector %0d", v), VECS[v].exp_cr, VECS[v].exp_ok);
      end

      // R2/R3/R4: every truth table over random register contents
      for (int n = 0; n < 300; n++) begin
         iw = $urandom;
         if (n % 5 == 0) iw[15:11] = iw[20:16]; // R3: A and B name the same bit
         run_model("R2 R3 R4 bit logic", 3'd1, iw, $urandom, $urandom);
      end
      // R5: field copies, with forced self copies
      for (int n = 0; n < 200; n++) begin
         iw = $urandom;
         if (n % 4 == 0) iw[20:18] = iw[25:23];
         run_model("R5 field copy", 3'd2, iw, $urandom, $urandom);
      end
      // R6/R7: masked moves incl. empty and full selects
      for (int n = 0; n < 200; n++) begin
         iw = $urandom;
         if (n % 10 == 0) iw[19:12] = 8'h00;
         if (n % 10 == 1) iw[19:12] = 8'hFF;
         run_model("R6 R7 masked move", 3'd3, iw, $urandom, $urandom);
      end
      // R1: unused codes 4..7 and 0
      for (int n = 0; n < 50; n++) begin
         run_model("R1 unsupported op", 3'(4 + (n % 4)), $urandom, $urandom, $urandom);
      end
      run_model("R1 unsupported op zero", 3'd0, $urandom, $urandom, $urandom);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule